// File: doc/BRIEF.md
# Paged Display RAM Host Port With Read Holder

The block is the host's window onto a paged display RAM of 89 rows by 104 columns. The RAM is held as 12 pages of byte-wide columns. Rows 0 to 87 fill pages 0 to 10, and bit 0 of a byte is the top line of its page. Page 11 carries a single icon line. The host sends a byte stream, marked either as a command or as display data. Commands load a page register and a column counter; the column counter is loaded in two halves. Each accepted data write or read moves the column on by one. The counter never carries into the page. Once it runs past the last column, it stays parked there until the host sets the column again.

Reads go through a one-byte holder. A read strobe hands the host whatever the holder already contains, then refills the holder from the current address. The first read after an address change therefore returns stale data and must be thrown away. Writes store the byte at the current address and leave a copy of it in the holder. A separate scan port reads one byte per cycle by page and segment, and it can reverse the column-to-segment order.

Top module: `dram_access`

## Requirements
- R1: After reset the page is 0, the column is 0, `rdata_o` is 0 and `scan_data_o` is 0.
- R2: A command is a write strobe with `dsel_i`=0. Upper nibble 0x1 loads column bits 6:4 from byte bits 2:0. Upper nibble 0x0 loads column bits 3:0 from byte bits 3:0. Upper nibble 0xB loads the 4-bit page from byte bits 3:0. Any other command byte changes nothing.
- R3: Every accepted data write or read raises the column by one. The page changes only through the set-page command, so the column never carries into it.
- R4: A column of 104 (0x68) or above is locked: it does not increment, and only a set-column command moves it. An access at column 0x67 still advances the column to 0x68.
- R5: A data write or read is ignored when the column is locked or the page is 12 or above. It leaves the RAM, the holder and the column unchanged.
- R6: `rdata_o` always shows the holder. An accepted read strobe returns that value, and at the next clock edge the holder is loaded with the RAM byte at the current address. The first read after an address set therefore returns stale data.
- R7: An accepted data write stores `wdata_i` at the current page and column and loads the holder with `wdata_i`.
- R8: Page 11 stores only data bit 0. Reads and scans of page 11 return 0 in bits 7:1.
- R9: `scan_data_o` gives, one cycle later, the byte at page `scan_page_i` and column `scan_seg_i`. When `col_rev_i`=1 the column is instead 103 minus `scan_seg_i`. A segment of 104 or above, or a page of 12 or above, yields 0.
- R10: A write strobe and a read strobe in the same cycle act as the write alone, and the column advances once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Host write strobe (command or data) |
| rd_i | input | 1 | Host read strobe (data only) |
| dsel_i | input | 1 | 1: display data, 0: command |
| wdata_i | input | 8 | Host write byte |
| rdata_o | output | 8 | Holder contents returned to the host |
| col_rev_i | input | 1 | Reverse column-to-segment mapping on the scan port |
| scan_page_i | input | 4 | Scan page |
| scan_seg_i | input | 7 | Scan segment |
| scan_data_o | output | 8 | Scanned byte, one cycle latency |

## Verification
The bench aims first at the holder lag. It checks that the first read after an address set returns the old holder byte and that the next read returns the RAM byte; a design that read through directly would return addressed data one read too early. It drives writes at columns 0x66 through 0x68, which exposes a counter that wraps or carries into the page, or a locked write that corrupts column 0 or the next page. It also checks icon-page masking, reversed and out-of-range scans, and simultaneous strobes. A design that let the read win, or advanced the column twice, would read back the wrong byte. Random command, data and scan traffic is compared against a bench model of the RAM, page, column and holder.

// File: rtl/dram_pkg.sv
package dram_pkg;

  typedef enum logic [1:0] {
    OP_NONE,
    OP_COL_HI,
    OP_COL_LO,
    OP_PAGE
  } cmd_e;

  localparam logic [3:0] OPC_COL_HI = 4'h1;
  localparam logic [3:0] OPC_COL_LO = 4'h0;
  localparam logic [3:0] OPC_PAGE   = 4'hB;

  function automatic cmd_e decode_cmd(input logic [3:0] opc);
    cmd_e r;
    case (opc)
      OPC_COL_HI: r = OP_COL_HI;
      OPC_COL_LO: r = OP_COL_LO;
      OPC_PAGE:   r = OP_PAGE;
      default:    r = OP_NONE;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/dram_addr_ctrl.sv
module dram_addr_ctrl
  import dram_pkg::*;
#(
  parameter int COLS   = 104,
  parameter int PAGES  = 12,
  parameter int COL_W  = 7,
  parameter int PAGE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  cmd_e              cmd_i,
  input  logic [3:0]        arg_i,
  input  logic              step_i,
  output logic [PAGE_W-1:0] page_o,
  output logic [COL_W-1:0]  col_o,
  output logic              in_range_o
);

  localparam logic [COL_W-1:0]  COLS_L  = COL_W'(COLS);
  localparam logic [PAGE_W-1:0] PAGES_L = PAGE_W'(PAGES);

  logic [COL_W-1:0]  col_q;
  logic [PAGE_W-1:0] page_q;
  logic              unused_arg;

  assign unused_arg = ^arg_i[3:COL_W-4];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_q  <= '0;
      page_q <= '0;
    end else begin
      case (cmd_i)
        OP_COL_HI: col_q  <= {arg_i[COL_W-5:0], col_q[3:0]};
        OP_COL_LO: col_q  <= {col_q[COL_W-1:4], arg_i};
        OP_PAGE:   page_q <= arg_i[PAGE_W-1:0];
        default: begin
          // locked above last column; only a set-column reopens it
          if (step_i && col_q < COLS_L) col_q <= col_q + 1'b1;
        end
      endcase
    end
  end

  assign page_o     = page_q;
  assign col_o      = col_q;
  assign in_range_o = (col_q < COLS_L) && (page_q < PAGES_L);

endmodule

// File: rtl/dram_mem.sv
module dram_mem #(
  parameter int COLS   = 104,
  parameter int PAGES  = 12,
  parameter int ROWS   = 89,
  parameter int COL_W  = 7,
  parameter int PAGE_W = 4
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [PAGE_W-1:0] hpage_i,
  input  logic [COL_W-1:0]  hcol_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        hdata_o,
  input  logic [PAGE_W-1:0] spage_i,
  input  logic [COL_W-1:0]  scol_i,
  output logic [7:0]        sdata_o
);

  localparam int DEPTH      = PAGES * COLS;
  localparam int IDX_W      = $clog2(DEPTH);
  localparam int LAST_LINES = ROWS - 8 * (PAGES - 1);

  logic [7:0] mem [DEPTH];
  logic [7:0] page_mask [PAGES];

  generate
    for (genvar p = 0; p < PAGES; p++) begin : g_mask
      if (p == PAGES - 1) begin : g_short
        assign page_mask[p] = 8'((1 << LAST_LINES) - 1);
      end else begin : g_full
        assign page_mask[p] = 8'hFF;
      end
    end
  endgenerate

  function automatic logic [IDX_W-1:0] flat(input logic [PAGE_W-1:0] pg,
                                            input logic [COL_W-1:0] cl);
    return IDX_W'(pg) * IDX_W'(COLS) + IDX_W'(cl);
  endfunction

  logic [IDX_W-1:0] hidx, sidx;
  assign hidx = flat(hpage_i, hcol_i);
  assign sidx = flat(spage_i, scol_i);

  always_ff @(posedge clk_i) begin
    if (we_i) mem[hidx] <= wdata_i & page_mask[hpage_i];
  end

  assign hdata_o = mem[hidx];
  assign sdata_o = mem[sidx];

endmodule

// File: rtl/dram_holder.sv
module dram_holder (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ld_wr_i,
  input  logic [7:0] wdata_i,
  input  logic       ld_rd_i,
  input  logic [7:0] ram_i,
  output logic [7:0] hold_o
);

  logic [7:0] hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      hold_q <= '0;
    else if (ld_wr_i) hold_q <= wdata_i;
    else if (ld_rd_i) hold_q <= ram_i;
  end

  assign hold_o = hold_q;

endmodule

// File: rtl/dram_seg_map.sv
module dram_seg_map #(
  parameter int COLS  = 104,
  parameter int COL_W = 7
) (
  input  logic [COL_W-1:0] seg_i,
  input  logic             rev_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o
);

  localparam logic [COL_W-1:0] COLS_L = COL_W'(COLS);
  localparam logic [COL_W-1:0] LAST_L = COL_W'(COLS - 1);

  assign valid_o = seg_i < COLS_L;
  assign col_o   = rev_i ? (LAST_L - seg_i) : seg_i;

endmodule

// File: rtl/dram_access.sv
module dram_access
  import dram_pkg::*;
#(
  parameter int COLS  = 104,
  parameter int PAGES = 12,
  parameter int ROWS  = 89,
  parameter int COL_W  = $clog2(COLS),
  parameter int PAGE_W = $clog2(PAGES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic              dsel_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  input  logic              col_rev_i,
  input  logic [PAGE_W-1:0] scan_page_i,
  input  logic [COL_W-1:0]  scan_seg_i,
  output logic [7:0]        scan_data_o
);

  localparam logic [PAGE_W-1:0] PAGES_L = PAGE_W'(PAGES);

  cmd_e              cmd;
  logic              in_range, acc_wr, acc_rd;
  logic [PAGE_W-1:0] page_q;
  logic [COL_W-1:0]  col_q;
  logic [7:0]        hdata, sdata;
  logic [COL_W-1:0]  scol;
  logic              seg_ok;
  logic [7:0]        scan_q;

  assign cmd    = (wr_i && !dsel_i) ? decode_cmd(wdata_i[7:4]) : OP_NONE;
  assign acc_wr = wr_i && dsel_i && in_range;
  assign acc_rd = rd_i && dsel_i && !wr_i && in_range;

  dram_addr_ctrl #(
    .COLS(COLS), .PAGES(PAGES), .COL_W(COL_W), .PAGE_W(PAGE_W)
  ) u_addr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_i      (cmd),
    .arg_i      (wdata_i[3:0]),
    .step_i     (acc_wr || acc_rd),
    .page_o     (page_q),
    .col_o      (col_q),
    .in_range_o (in_range)
  );

  dram_mem #(
    .COLS(COLS), .PAGES(PAGES), .ROWS(ROWS), .COL_W(COL_W), .PAGE_W(PAGE_W)
  ) u_mem (
    .clk_i   (clk_i),
    .we_i    (acc_wr),
    .hpage_i (page_q),
    .hcol_i  (col_q),
    .wdata_i (wdata_i),
    .hdata_o (hdata),
    .spage_i (scan_page_i),
    .scol_i  (scol),
    .sdata_o (sdata)
  );

  dram_holder u_hold (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ld_wr_i (acc_wr),
    .wdata_i (wdata_i),
    .ld_rd_i (acc_rd),
    .ram_i   (hdata),
    .hold_o  (rdata_o)
  );

  dram_seg_map #(.COLS(COLS), .COL_W(COL_W)) u_seg (
    .seg_i   (scan_seg_i),
    .rev_i   (col_rev_i),
    .col_o   (scol),
    .valid_o (seg_ok)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) scan_q <= '0;
    else         scan_q <= (seg_ok && scan_page_i < PAGES_L) ? sdata : 8'h00;
  end

  assign scan_data_o = scan_q;

endmodule

// File: rtl/dram_access_chk.sv
module dram_access_chk #(
  parameter int COLS   = 104,
  parameter int PAGES  = 12,
  parameter int ROWS   = 89,
  parameter int COL_W  = 7,
  parameter int PAGE_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_i,
  input logic              rd_i,
  input logic              dsel_i,
  input logic [7:0]        wdata_i,
  input logic [7:0]        rdata_o,
  input logic [PAGE_W-1:0] page_i,
  input logic [COL_W-1:0]  col_i,
  input logic [PAGE_W-1:0] scan_page_i,
  input logic [7:0]        scan_data_o
);

  localparam logic [COL_W-1:0]  COLS_L    = COL_W'(COLS);
  localparam logic [PAGE_W-1:0] PAGES_L   = PAGE_W'(PAGES);
  localparam logic [PAGE_W-1:0] LAST_PG   = PAGE_W'(PAGES - 1);
  localparam logic [COL_W-1:0]  ONE       = COL_W'(1);
  localparam logic [7:0]        LAST_MASK = 8'((1 << (ROWS - 8 * (PAGES - 1))) - 1);

  logic is_cmd, ok_addr, data_acc;
  assign is_cmd   = wr_i && !dsel_i;
  assign ok_addr  = (col_i < COLS_L) && (page_i < PAGES_L);
  assign data_acc = dsel_i && (wr_i || rd_i);

  AST_COL_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_acc && ok_addr) |=> col_i == $past(col_i) + ONE); // R3

  AST_PAGE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !is_cmd |=> $stable(page_i)); // R3

  AST_COL_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (col_i >= COLS_L && !is_cmd) |=> $stable(col_i)); // R4

  AST_OOR_IGNORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_acc && !ok_addr) |=> ($stable(rdata_o) && $stable(col_i))); // R5

  AST_HOLD_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && !rd_i) |=> $stable(rdata_o)); // R6

  AST_WR_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && dsel_i && ok_addr) |=> rdata_o == $past(wdata_i)); // R7

  AST_ICON_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scan_page_i == LAST_PG) |=> (scan_data_o & ~LAST_MASK) == 8'h00); // R8

endmodule

bind dram_access dram_access_chk #(
  .COLS(COLS), .PAGES(PAGES), .ROWS(ROWS), .COL_W(COL_W), .PAGE_W(PAGE_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_i        (wr_i),
  .rd_i        (rd_i),
  .dsel_i      (dsel_i),
  .wdata_i     (wdata_i),
  .rdata_o     (rdata_o),
  .page_i      (page_q),
  .col_i       (col_q),
  .scan_page_i (scan_page_i),
  .scan_data_o (scan_data_o)
);

// File: tb/dram_access_test.sv
`timescale 1ns/1ps
module dram_access_test;

  localparam int COLS  = 104;
  localparam int PAGES = 12;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_i = 1'b0, rd_i = 1'b0, dsel_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       col_rev_i = 1'b0;
  logic [3:0] scan_page_i = '0;
  logic [6:0] scan_seg_i = '0;
  logic [7:0] scan_data_o;

  int n_chk = 0, n_fail = 0;

  logic [7:0] m_mem [PAGES*COLS];
  int m_page = 0, m_col = 0;
  logic [7:0] m_hold = 8'h00;

  always #4 clk = ~clk;

  dram_access uut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_i(wr_i), .rd_i(rd_i), .dsel_i(dsel_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .col_rev_i(col_rev_i),
    .scan_page_i(scan_page_i), .scan_seg_i(scan_seg_i), .scan_data_o(scan_data_o)
  );

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  function automatic bit m_ok();
    return (m_col < COLS) && (m_page < PAGES);
  endfunction

  function automatic logic [7:0] m_scan(int pg, int sg, bit rev);
    if (pg >= PAGES || sg >= COLS) return 8'h00;
    return m_mem[pg*COLS + (rev ? COLS-1-sg : sg)];
  endfunction

  task automatic drive(bit w, bit r, bit d, logic [7:0] b);
    @(negedge clk);
    wr_i = w; rd_i = r; dsel_i = d; wdata_i = b;
    @(negedge clk);
    wr_i = 1'b0; rd_i = 1'b0; dsel_i = 1'b0;
  endtask

  // R2 encodings: 0x1h col[6:4], 0x0l col[3:0], 0xBp page
  task automatic cmd(logic [7:0] b);
    drive(1'b1, 1'b0, 1'b0, b);
    case (b[7:4])
      4'h1: m_col = {b[2:0], 4'(m_col)};
      4'h0: m_col = {3'(m_col >> 4), b[3:0]};
      4'hB: m_page = int'(b[3:0]);
      default: ;
    endcase
  endtask

  task automatic set_col(int c);
    cmd(8'h10 | 8'((c >> 4) & 7));
    cmd(8'h00 | 8'(c & 15));
  endtask

  task automatic wr_data(logic [7:0] b);
    drive(1'b1, 1'b0, 1'b1, b);
    if (m_ok()) begin
      m_mem[m_page*COLS + m_col] = (m_page == PAGES-1) ? (b & 8'h01) : b;
      m_hold = b;
      m_col++;
    end
  endtask

  task automatic rd_data(string tag);
    @(negedge clk);
    rd_i = 1'b1; dsel_i = 1'b1;
    check(tag, rdata_o, m_hold);
    @(negedge clk);
    rd_i = 1'b0; dsel_i = 1'b0;
    if (m_ok()) begin
      m_hold = m_mem[m_page*COLS + m_col];
      m_col++;
    end
  endtask

  task automatic scan(string tag, int pg, int sg, bit rev);
    @(negedge clk);
    scan_page_i = 4'(pg); scan_seg_i = 7'(sg); col_rev_i = rev;
    @(negedge clk);
    check(tag, scan_data_o, m_scan(pg, sg, rev));
  endtask

  initial begin
    #1_600_000;
    n_fail++; n_chk++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd7177));
    for (int i = 0; i < PAGES*COLS; i++) m_mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    check("R1 rdata after reset", rdata_o, 8'h00);
    check("R1 scan after reset", scan_data_o, 8'h00);
    rst_ni = 1'b1;
    // R1/R7: first write lands at page 0 col 0
    wr_data(8'h5A);
    scan("R1 first write at 0,0", 0, 0, 1'b0);
    check("R7 holder after write", rdata_o, 8'h5A);

    // fill every page via auto-increment (R3)
    for (int p = 0; p < PAGES; p++) begin
      cmd(8'hB0 | 8'(p));
      set_col(0);
      for (int c = 0; c < COLS; c++) wr_data(8'($urandom()));
    end
    for (int k = 0; k < 20; k++) scan("R3 fill", k % PAGES, (k * 37) % COLS, 1'b0);

    // R6: dummy read after address set
    cmd(8'hB3); set_col(10);
    rd_data("R6 dummy read stale");
    rd_data("R6 second read = addr 10");
    rd_data("R6 third read = addr 11");

    // R4/R5: lock at 0x68
    cmd(8'hB2); set_col(8'h66);
    wr_data(8'hA1); wr_data(8'hB2); wr_data(8'hC3);
    scan("R4 col 0x66", 2, 8'h66, 1'b0);
    scan("R4 col 0x67", 2, 8'h67, 1'b0);
    scan("R5 col 0 untouched", 2, 0, 1'b0);
    scan("R3 no carry to page 3", 3, 0, 1'b0);
    check("R5 holder kept on locked write", rdata_o, 8'hB2);
    rd_data("R5 locked read");
    rd_data("R5 locked read repeat");
    wr_data(8'h77);
    scan("R5 col 0 still untouched", 2, 0, 1'b0);

    // R2: unknown commands
    cmd(8'h55); cmd(8'hE3); cmd(8'h2F);
    rd_data("R2 unknown cmd keeps lock");
    set_col(5); cmd(8'h7A);
    wr_data(8'h3C);
    scan("R2 unknown cmd keeps col", 2, 5, 1'b0);

    // R8: icon page
    cmd(8'hBB); set_col(9);
    wr_data(8'hFF);
    scan("R8 icon scan", 11, 9, 1'b0);
    set_col(9);
    rd_data("R8 icon dummy");
    rd_data("R8 icon read");

    // R9: reversed and out-of-range scan
    scan("R9 rev seg0", 4, 0, 1'b1);
    scan("R9 rev seg103", 4, 103, 1'b1);
    scan("R9 seg 104", 4, 104, 1'b0);
    scan("R9 page 12", 12, 3, 1'b0);

    // R10: simultaneous strobes
    cmd(8'hB1); set_col(20);
    drive(1'b1, 1'b1, 1'b1, 8'hC3);
    m_mem[1*COLS + 20] = 8'hC3; m_hold = 8'hC3; m_col = 21;
    scan("R10 write won", 1, 20, 1'b0);
    rd_data("R10 holder has write byte");
    rd_data("R10 col advanced once");

    // R5: out-of-range page
    cmd(8'hBD); set_col(0);
    wr_data(8'h99);
    rd_data("R5 page 13 read");
    scan("R5 page 0 untouched", 0, 0, 1'b0);

    // random traffic
    for (int i = 0; i < 3000; i++) begin
      int op;
      op = int'($urandom_range(0, 9));
      case (op)
        0: cmd(8'hB0 | 8'($urandom_range(0, 13)));
        1: set_col(int'($urandom_range(0, 110)));
        2, 3, 4: wr_data(8'($urandom()));
        5, 6, 7: rd_data("R6 random read");
        default: scan("R9 random scan", int'($urandom_range(0, 13)),
                      int'($urandom_range(0, 110)), 1'($urandom()));
      endcase
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule